// File: doc/BRIEF.md
# SPI Byte FIFOs with Event and Interrupt Logic

This block sits between a register bus and the serial shift engine of an SPI master. It holds two byte queues. The transmit queue is filled from the bus and drained one byte at a time by the shift engine. The receive queue is filled one byte at a time by the shift engine and drained from the bus. The bus can access either data port with 8-, 16- or 32-bit transfers. A multi-byte access moves several bytes in one cycle, and the most significant byte is the first in the stream.

An event word reports the state of both queues. It gives the live fill level of the receive queue and the live free space of the transmit queue. It also holds a set of sticky status flags. Software clears a flag by writing a one to its bit position. A mask word selects which flags drive the single interrupt line. A control word holds two 6-bit threshold levels, which set when the threshold flags fire.

Register map (byte offsets on `bus_addr`):
- 0x00: control word.
- 0x04: event word.
- 0x08: mask word.
- 0x0C: transmit data port.
- 0x10: receive data port.

`bus_size` encodes the access width: 0 is a byte, 1 is 16 bits, 2 or 3 is 32 bits.

Top module: `spi_fifo_evt_unit`

## Requirements
- R1: After reset the control word reads 0x0000040F, the mask word reads 0, and `irq` is low.
- R2: A transmit-port write pushes its bytes in big-endian order. A 32-bit write pushes bits 31:24 first and bits 7:0 last. A 16-bit write pushes bits 15:8 and then bits 7:0. A byte write pushes bits 7:0. The shift engine receives the bytes in the same order they were pushed.
- R3: The transmit queue holds 32 bytes. Bytes pushed into a full queue are dropped and never reach the shift engine.
- R4: A receive-port read pops bytes into the read word most significant first. For a 32-bit read the first byte lands in bits 31:24. For a 16-bit read it lands in bits 15:8. Byte lanes with no data behind them read as zero. A read from an empty queue returns 0 and pops nothing.
- R5: The receive queue holds 32 bytes. A byte from the shift engine that arrives while the queue is full is dropped.
- R6: Event word bits 29:24 give the receive fill count. Bits 21:16 give the transmit free-space count. Both are live values.
- R7: Each flag sets when its condition holds:
  - bit 15: transmit queue empty.
  - bit 8: transmit queue not full.
  - bit 9: receive queue not empty.
  - bit 12: receive queue full.
  - bit 13: receive count greater than the receive threshold.
  - bit 11: transmit free space greater than the transmit threshold.
  - All other event bits 15:0 read 0.
- R8: Flags are sticky. A flag stays set after its condition ends. Writing a 1 to its bit in the event word clears it, unless the condition still holds. Writing 0 bits has no effect.
- R9: A one-cycle pulse on `eng_done` sets flag bit 14.
- R10: `irq` is high exactly when some flag is set and its mask bit is also set. The mask word keeps only bits 15:11 and 9:8, and its other bits read 0.
- R11: The receive threshold sits in control bits 5:0 and the transmit threshold in control bits 13:8. Both are writable and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive queue at the receive port |
| bus_addr | input | 5 | Byte offset of the register |
| bus_size | input | 2 | Access width: 0 is a byte, 1 is 16 bits, 2 or 3 is 32 bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| eng_tx_valid | output | 1 | Transmit queue holds at least one byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_take | input | 1 | Shift engine pops one transmit byte |
| eng_rx_push | input | 1 | Shift engine delivers one received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_done | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the exact queue boundaries: a full queue that is offered one more byte, and a partial 32-bit read that runs past the last stored byte. The stimulus stops the shift-engine sink while it writes nine words, so the last word meets a full transmit queue. It then re-enables the sink, and any byte beyond the 32 expected shows up as an unexpected item in the scoreboard. On the receive side, 33 bytes are fed into the queue, and a 3-byte fill is read with a 32-bit access. Because flags are sticky, each event-word check first clears the whole word and waits for the live conditions to set their flags again. This isolates the current state from earlier history.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_EVT  = 5'h04;
  localparam logic [4:0] A_MASK = 5'h08;
  localparam logic [4:0] A_TXD  = 5'h0C;
  localparam logic [4:0] A_RXD  = 5'h10;

  localparam int B_TXE = 15;
  localparam int B_DON = 14;
  localparam int B_RXT = 13;
  localparam int B_RXF = 12;
  localparam int B_TXT = 11;
  localparam int B_RNE = 9;
  localparam int B_TNF = 8;

  localparam logic [15:0] FLAG_BITS = 16'hFB00;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  // lane 0 is the first byte of the stream
  typedef logic [3:0][7:0] lanes_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic lanes_t split_tx(input logic [31:0] w, input logic [1:0] sz);
    lanes_t l;
    l = '0;
    case (acc_size_e'(sz))
      SZ_BYTE: l[0] = w[7:0];
      SZ_HALF: begin
        l[0] = w[15:8];
        l[1] = w[7:0];
      end
      default: begin
        l[0] = w[31:24];
        l[1] = w[23:16];
        l[2] = w[15:8];
        l[3] = w[7:0];
      end
    endcase
    return l;
  endfunction

  function automatic logic [31:0] pack_rx(input lanes_t p, input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return {24'h0, p[0]};
      SZ_HALF: return {16'h0, p[0], p[1]};
      default: return {p[0], p[1], p[2], p[3]};
    endcase
  endfunction

  // bytes actually moved: the request, limited by what the queue allows
  function automatic logic [2:0] clamp_moves(input logic [2:0] want, input int room);
    if (int'(want) <= room) return want;
    return 3'(room);
  endfunction

endpackage

// File: rtl/sff_byte_fifo.sv
module sff_byte_fifo
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IN_L  = 4,
  parameter int OUT_L = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            push_n,
  input  logic [IN_L-1:0][7:0]  push_data,
  input  logic [2:0]            pop_n,
  output logic [OUT_L-1:0][7:0] peek,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [2:0]    push_ok, pop_ok;

  always_comb begin
    push_ok = clamp_moves(push_n, DEPTH - int'(count));
    pop_ok  = clamp_moves(pop_n, int'(count));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_ok);
      rd_ptr <= rd_ptr + AW'(pop_ok);
      count  <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < IN_L; k++) begin
      if (k < int'(push_ok)) mem[wr_ptr + AW'(k)] <= push_data[k];
    end
  end

  for (genvar k = 0; k < OUT_L; k++) begin : g_peek
    assign peek[k] = (CW'(k) < count) ? mem[rd_ptr + AW'(k)] : 8'h00;
  end

endmodule

// File: rtl/sff_event_flags.sv
module sff_event_flags
  import spi_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cond,
  input  logic        clr_we,
  input  logic [15:0] clr_bits,
  output logic [15:0] flags
);
  logic [15:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : 16'h0;

  // a live condition wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= ((flags & ~clr_eff) | cond) & FLAG_BITS;
  end

endmodule

// File: rtl/spi_fifo_evt_unit.sv
module spi_fifo_evt_unit
  import spi_fifo_pkg::*;
#(
  parameter int          DEPTH     = 32,
  parameter logic [5:0]  RXTHR_RST = 6'd15,
  parameter logic [5:0]  TXTHR_RST = 6'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        eng_tx_valid,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_tx_take,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_done,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  // named internal events, also observed by the checker
  logic          wr_ctrl, wr_evt, wr_mask, wr_txd, rd_rxd;
  logic [CW-1:0] tx_count, rx_count, tx_free;
  logic [15:0]   flags_q, mask_q, cond;
  logic [5:0]    rx_thr_q, tx_thr_q;
  logic [2:0]    tx_push_n, rx_pop_n;
  lanes_t        tx_lanes, rx_peek;
  logic [0:0][7:0] tx_peek;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_evt  = bus_wr && (bus_addr == A_EVT);
  assign wr_mask = bus_wr && (bus_addr == A_MASK);
  assign wr_txd  = bus_wr && (bus_addr == A_TXD);
  assign rd_rxd  = bus_rd && (bus_addr == A_RXD);

  assign tx_push_n = wr_txd ? size_bytes(bus_size) : 3'd0;
  assign rx_pop_n  = rd_rxd ? size_bytes(bus_size) : 3'd0;
  assign tx_lanes  = split_tx(bus_wdata, bus_size);

  sff_byte_fifo #(.DEPTH(DEPTH), .IN_L(4), .OUT_L(1)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (tx_push_n),
    .push_data(tx_lanes),
    .pop_n    ({2'b00, eng_tx_take}),
    .peek     (tx_peek),
    .count    (tx_count)
  );

  sff_byte_fifo #(.DEPTH(DEPTH), .IN_L(1), .OUT_L(4)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   ({2'b00, eng_rx_push}),
    .push_data(eng_rx_data),
    .pop_n    (rx_pop_n),
    .peek     (rx_peek),
    .count    (rx_count)
  );

  assign tx_free      = CW'(DEPTH) - tx_count;
  assign eng_tx_valid = (tx_count != '0);
  assign eng_tx_data  = tx_peek[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr_q <= RXTHR_RST;
      tx_thr_q <= TXTHR_RST;
      mask_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_thr_q <= bus_wdata[5:0];
        tx_thr_q <= bus_wdata[13:8];
      end
      if (wr_mask) mask_q <= bus_wdata[15:0] & FLAG_BITS;
    end
  end

  always_comb begin
    cond        = '0;
    cond[B_TXE] = (tx_count == '0);
    cond[B_DON] = eng_done;
    cond[B_RXT] = (rx_count > CW'(rx_thr_q));
    cond[B_RXF] = (rx_count == CW'(DEPTH));
    cond[B_TXT] = (tx_free > CW'(tx_thr_q));
    cond[B_RNE] = (rx_count != '0);
    cond[B_TNF] = (tx_count != CW'(DEPTH));
  end

  sff_event_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (cond),
    .clr_we  (wr_evt),
    .clr_bits(bus_wdata[15:0]),
    .flags   (flags_q)
  );

  assign irq = |(flags_q & mask_q);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {18'h0, tx_thr_q, 2'b00, rx_thr_q};
      A_EVT:   bus_rdata = {2'b00, 6'(rx_count), 2'b00, 6'(tx_free), flags_q};
      A_MASK:  bus_rdata = {16'h0, mask_q};
      A_RXD:   bus_rdata = pack_rx(rx_peek, bus_size);
      default: bus_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/spi_fifo_evt_chk.sv
module spi_fifo_evt_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [4:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        eng_tx_take,
  input logic        eng_done,
  input logic        irq,
  input logic [$clog2(DEPTH+1)-1:0] tx_count,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic [15:0] flags_q,
  input logic [15:0] mask_q
);
  localparam int CW = $clog2(DEPTH + 1);

  a_r3_tx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  a_r3_full_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CW'(DEPTH) && !eng_tx_take) |=> (tx_count == CW'(DEPTH)));

  a_r5_full_rx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(DEPTH) && !(bus_rd && bus_addr == A_RXD)) |=> (rx_count == CW'(DEPTH)));

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RXD && rx_count == '0) |-> (bus_rdata == 32'h0));

  a_r9_done_latches: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> flags_q[B_DON]);

  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EVT && bus_wdata[B_DON] && !eng_done) |=> !flags_q[B_DON]);

  a_r7_rxf_follows_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(DEPTH)) |=> flags_q[B_RXF]);

  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 16'h0));

endmodule

bind spi_fifo_evt_unit spi_fifo_evt_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .eng_tx_take(eng_tx_take),
  .eng_done   (eng_done),
  .irq        (irq),
  .tx_count   (tx_count),
  .rx_count   (rx_count),
  .flags_q    (flags_q),
  .mask_q     (mask_q)
);

// File: tb/test_spi_fifo_evt_unit.sv
`timescale 1ns/1ps
module test_spi_fifo_evt_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_tx_valid;
  logic [7:0]  eng_tx_data;
  logic        eng_tx_take = 1'b0;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_done = 1'b0;
  logic        irq;

  int   n_chk = 0, n_bad = 0;
  bit   drain_en = 1'b0;
  bit   finished = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];

  always #2.5 clk = ~clk;

  spi_fifo_evt_unit i_spi_fifo_evt_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
    .eng_tx_take(eng_tx_take), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_done(eng_done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, 2'd2, d);
    chk(tag, d, exp);
  endtask

  // driver: expected stream order is most significant byte first
  task automatic tx_write(input logic [31:0] d, input logic [1:0] sz, input int n_keep);
    int nb = nbytes(sz);
    for (int i = 0; i < nb; i++)
      if (i < n_keep) exp_tx.push_back(d[8*(nb-1-i) +: 8]);
    bus_write(5'h0C, sz, d);
  endtask

  task automatic rx_feed(input logic [7:0] b);
    if (exp_rx.size() < 32) exp_rx.push_back(b);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic rx_read(input string tag, input logic [1:0] sz);
    int nb = nbytes(sz);
    logic [31:0] e = '0;
    logic [31:0] d;
    for (int i = 0; i < nb; i++)
      if (exp_rx.size() != 0) e[8*(nb-1-i) +: 8] = exp_rx.pop_front();
    bus_read(5'h10, sz, d);
    chk(tag, d, e);
  endtask

  task automatic clear_events();
    bus_write(5'h04, 2'd2, 32'hFFFF_FFFF);
    idle(2);
  endtask

  // monitor: shift-engine sink compares every byte against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (drain_en && eng_tx_valid) begin
        eng_tx_take = 1'b1;
        if (exp_tx.size() == 0) chk("R3 unexpected tx byte", {24'h0, eng_tx_data}, 32'hFFFF_FFFF);
        else                    chk("R2 tx byte order", {24'h0, eng_tx_data}, {24'h0, exp_tx.pop_front()});
      end else begin
        eng_tx_take = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(4);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state, R6/R7 idle event word
    read_chk("R1 ctrl reset", 5'h00, 32'h0000_040F);
    read_chk("R1 mask reset", 5'h08, 32'h0);
    chk("R1 irq reset", {31'h0, irq}, 32'h0);
    read_chk("R6 R7 idle event", 5'h04, 32'h0020_8900);

    // R2 byte ordering for all widths
    drain_en = 1'b1;
    tx_write(32'hA1B2_C3D4, 2'd2, 4);
    tx_write(32'h0000_1234, 2'd1, 2);
    tx_write(32'h0000_005A, 2'd0, 1);
    tx_write(32'hCAFE_F00D, 2'd3, 4);
    while (exp_tx.size() != 0) @(negedge clk);
    idle(3);

    // R3 overflow of transmit queue
    drain_en = 1'b0;
    idle(2);
    for (int i = 0; i < 8; i++) tx_write(32'h0102_0304 + 32'h0404_0404 * i, 2'd2, 4);
    tx_write(32'hDEAD_BEEF, 2'd2, 0);
    idle(2);
    clear_events();
    read_chk("R3 full tx event", 5'h04, 32'h0000_0000);
    drain_en = 1'b1;
    while (exp_tx.size() != 0) @(negedge clk);
    idle(6);
    read_chk("R6 tx drained event", 5'h04, 32'h0020_8900);

    // R4 receive packing, partial and empty reads
    for (int i = 1; i <= 5; i++) rx_feed(8'(8'h11 * i));
    idle(1);
    clear_events();
    read_chk("R6 R7 rx five", 5'h04, 32'h0520_8B00);
    rx_read("R4 word read", 2'd2);
    rx_read("R4 half read partial", 2'd1);
    rx_read("R4 empty byte read", 2'd0);
    rx_read("R4 empty word read", 2'd2);

    // R8 sticky and write-one-to-clear
    read_chk("R8 rne sticky", 5'h04, 32'h0020_8B00);
    bus_write(5'h04, 2'd2, 32'h0000_0000);
    idle(1);
    read_chk("R8 zero write no effect", 5'h04, 32'h0020_8B00);
    bus_write(5'h04, 2'd2, 32'h0000_0200);
    idle(1);
    read_chk("R8 w1c rne", 5'h04, 32'h0020_8900);

    // R5 receive overflow
    for (int i = 0; i < 33; i++) rx_feed(8'(i * 7 + 3));
    idle(1);
    clear_events();
    read_chk("R5 R7 rx full event", 5'h04, 32'h2020_BB00);
    for (int i = 0; i < 8; i++) rx_read("R5 rx full drain", 2'd2);
    rx_read("R5 dropped byte absent", 2'd2);

    // R11 thresholds
    bus_write(5'h00, 2'd2, 32'h0000_1F02);
    read_chk("R11 ctrl readback", 5'h00, 32'h0000_1F02);
    rx_feed(8'hE1); rx_feed(8'hE2); rx_feed(8'hE3);
    idle(1);
    clear_events();
    read_chk("R11 R7 thresholds fire", 5'h04, 32'h0320_AB00);
    bus_write(5'h00, 2'd2, 32'h0000_2002);
    clear_events();
    read_chk("R11 R7 tx threshold equal", 5'h04, 32'h0320_A300);
    rx_read("R4 three byte word", 2'd2);
    bus_write(5'h00, 2'd2, 32'h0000_040F);

    // R9 done flag, R10 interrupt gating
    bus_write(5'h08, 2'd2, 32'h0000_4000);
    clear_events();
    chk("R10 irq masked off", {31'h0, irq}, 32'h0);
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    @(negedge clk);
    chk("R9 R10 irq on done", {31'h0, irq}, 32'h1);
    bus_read(5'h04, 2'd2, d);
    chk("R9 done bit", d & 32'h0000_4000, 32'h0000_4000);
    bus_write(5'h04, 2'd2, 32'h0000_4000);
    idle(1);
    chk("R8 R10 irq cleared", {31'h0, irq}, 32'h0);
    bus_write(5'h08, 2'd2, 32'h0000_0100);
    idle(1);
    chk("R10 irq live tnf", {31'h0, irq}, 32'h1);
    bus_write(5'h08, 2'd2, 32'h0000_FFFF);
    read_chk("R10 mask reserved bits", 5'h08, 32'h0000_FB00);

    idle(2);
    finish_run();
  end

endmodule